// File: doc/BRIEF.md
# Class-Based Switch Input Port Controller

This block runs one input port of a combined input/output queued packet switch. Fixed-size cells arrive tagged with a traffic class (0 is the most urgent class and 4 the least) and with a destination output port. Each cell is written into the logical FIFO of its class. All five FIFOs are linked lists threaded through one shared cell store of `DEPTH` entries, so any class can use any free entry.

Each clock cycle is one time slot. The controller picks one non-empty class in round-robin order and looks at the head cell of that class. It raises exactly one bit of a one-hot request vector, the bit for the head cell's destination output scheduler. If the scheduler acknowledges in the same slot, the cell leaves on the cell output at once. The round-robin pointer then moves past the served class. If no acknowledge comes, the same head cell is requested again in the next slot, which is the head-of-line blocking this architecture is meant to model. Cells that find the store full, and cells with an unknown class tag, are dropped and counted.

The cell input is a valid-only stream with no back-pressure: the port never stalls the sender and never asks it to hold a cell. The cell output is qualified by `out_valid`. The acknowledge is the handshake for the output: a cell leaves only in a slot where `ack_i` meets a raised request. The output cannot be stalled once it is acknowledged.

Top module: `iport_cls_ctrl`

## Requirements
- R1: After a synchronous reset, `req_o` is all zero, `out_valid` is 0 and `drop_cnt` is 0.
- R2: Cells of one class leave in the order they arrived, carrying the data, class and destination they arrived with.
- R3: `req_o` is zero when all queues are empty. Otherwise it has exactly one bit set: bit `d`, where `d` is the destination of the head cell of the selected class.
- R4: The class for a slot is the first non-empty class found by scanning cyclically from the pointer (0,1,2,3,4,0,...). After an acknowledged slot that served class `c`, the pointer becomes `(c+1) mod 5`.
- R5: In a slot that raises a request but gets no acknowledge, nothing is dequeued, the pointer moves to the served class, and the next slot requests the same head cell. This holds even when cells arrive meanwhile in other classes.
- R6: `out_valid` is 1 exactly in slots where `ack_i` is 1 and a request is raised. In such a slot, `out_data`, `out_cls` and `out_dst` show the requested head cell. An `ack_i` that comes with no request has no effect.
- R7: An arriving cell is dropped when all `DEPTH` store entries are occupied at the start of the slot, even if a cell leaves in that same slot. Each drop adds 1 to `drop_cnt`, and the stored cells are not affected.
- R8: An arriving cell whose class tag is 5, 6 or 7 is dropped and counted in `drop_cnt` the same way.
- R9: `drop_cnt` saturates at `2**DROP_W-1`.
- R10: A slot may enqueue and dequeue at once, including on the same class when that class holds a single cell. The arriving cell then becomes the new head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Arriving cell present this slot |
| in_cls | input | 3 | Class tag of the arriving cell (0..4 valid) |
| in_dst | input | $clog2(NUM_OUT) | Destination output of the arriving cell |
| in_data | input | DATA_W | Cell payload |
| req_o | output | NUM_OUT | One-hot request to output schedulers, zero = none |
| ack_i | input | 1 | Acknowledge from the requested scheduler |
| out_valid | output | 1 | Cell leaves toward the crossbar this slot |
| out_data | output | DATA_W | Payload of the departing cell |
| out_cls | output | 3 | Class of the departing cell |
| out_dst | output | $clog2(NUM_OUT) | Destination of the departing cell |
| drop_cnt | output | DROP_W | Saturating count of dropped cells |

## Verification
The bench sweeps every class and destination pair. It also runs a long pseudo-random mix of arrivals, invalid tags and acknowledges against an arithmetic queue model. It goes after a single-cell class that is drained and refilled in the same slot. A design with broken linking there would lose the new cell or replay a freed entry. It withholds the acknowledge while other classes fill. A design that re-arbitrates every slot would then switch its request instead of holding the blocked head. It also covers arrival into a full store during a departure, where a design that frees the entry first would accept a cell it should drop. Finally it drives hundreds of drops, where a counter without saturation would wrap to a small value.

// File: rtl/iport_cls_pkg.sv
package iport_cls_pkg;
  localparam int NUM_CLS = 5;
  localparam int CLS_W   = 3;

  function automatic logic [CLS_W-1:0] cls_succ(input logic [CLS_W-1:0] c);
    return (c == CLS_W'(NUM_CLS - 1)) ? '0 : c + 1'b1;
  endfunction
endpackage

// File: rtl/iport_free_alloc.sv
module iport_free_alloc #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic             free_en,
  input  logic [PTR_W-1:0] free_idx,
  output logic [PTR_W-1:0] alloc_idx,
  output logic             any_free
);
  logic [DEPTH-1:0] free_q;

  // lowest free entry wins
  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_idx = PTR_W'(i);
    end
  end

  assign any_free = |free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
    end else begin
      free_q <= (free_q & ~(DEPTH'(alloc_en) << alloc_idx))
              | (DEPTH'(free_en) << free_idx);
    end
  end
endmodule

// File: rtl/iport_link_store.sv
module iport_link_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int DST_W  = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DST_W-1:0]  wr_dst,
  input  logic              lk_en,
  input  logic [PTR_W-1:0]  lk_idx,
  input  logic [PTR_W-1:0]  lk_val,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DST_W-1:0]  rd_dst,
  output logic [PTR_W-1:0]  rd_next
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DST_W-1:0]  dst_mem  [DEPTH];
  logic [PTR_W-1:0]  next_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_idx] <= wr_data;
      dst_mem[wr_idx]  <= wr_dst;
    end
    if (lk_en) next_mem[lk_idx] <= lk_val;
  end

  assign rd_data = data_mem[rd_idx];
  assign rd_dst  = dst_mem[rd_idx];
  assign rd_next = next_mem[rd_idx];
endmodule

// File: rtl/iport_rr_pick.sv
module iport_rr_pick
  import iport_cls_pkg::*;
(
  input  logic [NUM_CLS-1:0] nonempty,
  input  logic [CLS_W-1:0]   ptr,
  output logic [CLS_W-1:0]   sel,
  output logic               any
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    // scan from farthest offset down so the nearest non-empty class wins
    for (int i = NUM_CLS - 1; i >= 0; i--) begin
      int k;
      k = int'(ptr) + i;
      if (k >= NUM_CLS) k = k - NUM_CLS;
      if (nonempty[k]) begin
        any = 1'b1;
        sel = CLS_W'(k);
      end
    end
  end
endmodule

// File: rtl/iport_cls_ctrl.sv
module iport_cls_ctrl
  import iport_cls_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 8,
  parameter int DROP_W  = 8,
  localparam int DST_W  = $clog2(NUM_OUT),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic [DST_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_data,
  output logic [NUM_OUT-1:0] req_o,
  input  logic              ack_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CLS_W-1:0]  out_cls,
  output logic [DST_W-1:0]  out_dst,
  output logic [DROP_W-1:0] drop_cnt
);
  logic [PTR_W-1:0] head_q [NUM_CLS];
  logic [PTR_W-1:0] tail_q [NUM_CLS];
  logic [CNT_W-1:0] cnt_q  [NUM_CLS];
  logic [CLS_W-1:0] ptr_q;

  logic [NUM_CLS-1:0] nonempty;
  logic [NUM_CLS-1:0] enq_hit;
  logic [NUM_CLS-1:0] deq_hit;
  logic [CLS_W-1:0]   sel;
  logic               any_req;
  logic               any_free;
  logic [PTR_W-1:0]   alloc_idx;
  logic [PTR_W-1:0]   rd_next;
  logic [DST_W-1:0]   rd_dst;
  logic [DATA_W-1:0]  rd_data;
  logic               cls_ok, enq_ok, deq, drop;
  logic [PTR_W-1:0]   in_tail;
  logic [CNT_W-1:0]   in_cnt;

  assign cls_ok = in_cls < CLS_W'(NUM_CLS);
  assign enq_ok = in_valid && cls_ok && any_free;
  assign drop   = in_valid && !enq_ok;
  assign deq    = ack_i && any_req;

  // per-class strobes
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign nonempty[c] = cnt_q[c] != '0;
    assign enq_hit[c]  = enq_ok && (in_cls == CLS_W'(c));
    assign deq_hit[c]  = deq && (sel == CLS_W'(c));
  end

  always_comb begin
    in_tail = '0;
    in_cnt  = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (in_cls == CLS_W'(c)) begin
        in_tail = tail_q[c];
        in_cnt  = cnt_q[c];
      end
    end
  end

  iport_rr_pick u_pick (
    .nonempty (nonempty),
    .ptr      (ptr_q),
    .sel      (sel),
    .any      (any_req)
  );

  iport_free_alloc #(.DEPTH(DEPTH)) u_free (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (enq_ok),
    .free_en   (deq),
    .free_idx  (head_q[sel]),
    .alloc_idx (alloc_idx),
    .any_free  (any_free)
  );

  iport_link_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DST_W(DST_W)) u_store (
    .clk     (clk),
    .wr_en   (enq_ok),
    .wr_idx  (alloc_idx),
    .wr_data (in_data),
    .wr_dst  (in_dst),
    .lk_en   (enq_ok && in_cnt != '0),
    .lk_idx  (in_tail),
    .lk_val  (alloc_idx),
    .rd_idx  (head_q[sel]),
    .rd_data (rd_data),
    .rd_dst  (rd_dst),
    .rd_next (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CLS; c++) begin
        head_q[c] <= '0;
        tail_q[c] <= '0;
        cnt_q[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CLS; c++) begin
        if (enq_hit[c] && (cnt_q[c] == '0 || (deq_hit[c] && cnt_q[c] == CNT_W'(1))))
          head_q[c] <= alloc_idx;
        else if (deq_hit[c])
          head_q[c] <= rd_next;
        if (enq_hit[c]) tail_q[c] <= alloc_idx;
        cnt_q[c] <= cnt_q[c] + CNT_W'(enq_hit[c]) - CNT_W'(deq_hit[c]);
      end
    end
  end

  // pointer: past the served class on ack, parked on it while blocked
  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (any_req) ptr_q <= ack_i ? cls_succ(sel) : sel;
  end

  always_ff @(posedge clk) begin
    if (rst) drop_cnt <= '0;
    else if (drop && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
  end

  assign req_o     = any_req ? (NUM_OUT'(1) << rd_dst) : '0;
  assign out_valid = deq;
  assign out_data  = rd_data;
  assign out_cls   = sel;
  assign out_dst   = rd_dst;
endmodule

// File: rtl/iport_cls_ctrl_chk.sv
module iport_cls_ctrl_chk #(
  parameter int NUM_OUT = 4,
  parameter int DROP_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OUT-1:0] req_o,
  input logic               ack_i,
  input logic               out_valid,
  input logic [DROP_W-1:0]  drop_cnt
);
  // R3
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(req_o));

  // R6
  out_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ack_i && req_o != '0));

  // R5
  blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o != '0 && !ack_i) |=> $stable(req_o));

  // R9
  drop_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drop_cnt >= $past(drop_cnt));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (drop_cnt == '0 && req_o == '0 && !out_valid));
endmodule

bind iport_cls_ctrl iport_cls_ctrl_chk #(.NUM_OUT(NUM_OUT), .DROP_W(DROP_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_o     (req_o),
  .ack_i     (ack_i),
  .out_valid (out_valid),
  .drop_cnt  (drop_cnt)
);

// File: tb/iport_cls_ctrl_tb.sv
module iport_cls_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OUT = 4;
  localparam int DEPTH   = 8;
  localparam int DATA_W  = 8;
  localparam int DROP_W  = 8;
  localparam int NCLS    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_cls = '0;
  logic [1:0] in_dst = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic ack_i = 1'b0;
  logic [NUM_OUT-1:0] req_o;
  logic out_valid;
  logic [DATA_W-1:0] out_data;
  logic [2:0] out_cls;
  logic [1:0] out_dst;
  logic [DROP_W-1:0] drop_cnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iport_cls_ctrl #(.NUM_OUT(NUM_OUT), .DEPTH(DEPTH), .DATA_W(DATA_W), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_dst(in_dst),
    .in_data(in_data), .req_o(req_o), .ack_i(ack_i), .out_valid(out_valid),
    .out_data(out_data), .out_cls(out_cls), .out_dst(out_dst), .drop_cnt(drop_cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench queue model
  int mdata [NCLS][DEPTH];
  int mdst  [NCLS][DEPTH];
  int mcnt  [NCLS];
  int mptr = 0;
  int mdrop = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic slot(input bit v, input int cls, input int dst, input int dat,
                      input bit ack, input string tag);
    int sel, total, edst;
    bit any;
    in_valid = v; in_cls = 3'(cls); in_dst = 2'(dst); in_data = 8'(dat); ack_i = ack;
    #1;
    any = 0; sel = 0;
    for (int i = 0; i < NCLS; i++) begin
      int k;
      k = (mptr + i) % NCLS;
      if (!any && mcnt[k] > 0) begin any = 1; sel = k; end
    end
    edst = any ? mdst[sel][0] : 0;
    chk(req_o == (any ? (NUM_OUT'(1) << edst) : '0), {tag, " R3 req"}, int'(req_o),
        any ? (1 << edst) : 0);
    chk(out_valid == (ack && any), {tag, " R6 out_valid"}, int'(out_valid), int'(ack && any));
    if (ack && any) begin
      chk(out_data == 8'(mdata[sel][0]), {tag, " R2 data"}, int'(out_data), mdata[sel][0]);
      chk(out_cls == 3'(sel), {tag, " R4 cls"}, int'(out_cls), sel);
      chk(out_dst == 2'(edst), {tag, " R2 dst"}, int'(out_dst), edst);
    end
    chk(drop_cnt == 8'(mdrop), {tag, " R7 drop_cnt"}, int'(drop_cnt), mdrop);
    // model update for the coming edge
    total = 0;
    for (int c = 0; c < NCLS; c++) total += mcnt[c];
    if (ack && any) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        mdata[sel][j] = mdata[sel][j+1];
        mdst[sel][j]  = mdst[sel][j+1];
      end
      mcnt[sel]--;
    end
    if (v) begin
      if (cls >= NCLS || total >= DEPTH) begin
        if (mdrop < 255) mdrop++;
      end else begin
        mdata[cls][mcnt[cls]] = dat & 8'hff;
        mdst[cls][mcnt[cls]]  = dst;
        mcnt[cls]++;
      end
    end
    if (any) mptr = ack ? (sel + 1) % NCLS : sel;
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3 * DEPTH; i++) slot(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    for (int c = 0; c < NCLS; c++) mcnt[c] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_o == '0, "R1 req at reset", int'(req_o), 0);
    chk(out_valid == 1'b0, "R1 out_valid at reset", int'(out_valid), 0);
    chk(drop_cnt == '0, "R1 drop_cnt at reset", int'(drop_cnt), 0);
    rst = 1'b0;
    slot(0, 0, 0, 0, 0, "R1 idle");
    slot(0, 0, 0, 0, 1, "R6 ack without request");

    // R2/R3: every class and destination pair
    for (int c = 0; c < NCLS; c++)
      for (int d = 0; d < NUM_OUT; d++) begin
        slot(1, c, d, c * 16 + d, 0, "R3 sweep enq");
        slot(0, 0, 0, 0, 1, "R2 sweep deq");
      end

    // R4: one cell per class, served cyclically; refill behind pointer
    for (int c = 0; c < NCLS; c++) slot(1, c, c % NUM_OUT, 100 + c, 0, "R4 fill");
    slot(0, 0, 0, 0, 1, "R4 serve");
    slot(1, 0, 3, 120, 1, "R4 serve");
    drain("R4 drain");

    // R5: blocked head held while other classes fill
    slot(1, 3, 2, 77, 0, "R5 load");
    slot(1, 0, 1, 78, 0, "R5 blocked");
    slot(1, 1, 0, 79, 0, "R5 blocked");
    slot(0, 0, 0, 0, 0, "R5 blocked");
    drain("R5 drain");

    // R10: single-cell class drained and refilled in one slot
    slot(1, 2, 1, 50, 0, "R10 load");
    slot(1, 2, 3, 51, 1, "R10 swap");
    slot(1, 2, 0, 52, 1, "R10 swap");
    drain("R10 drain");

    // R7: full store, arrival during departure still dropped
    for (int i = 0; i < DEPTH; i++) slot(1, i % NCLS, i % NUM_OUT, 200 + i, 0, "R7 fill");
    slot(1, 4, 1, 230, 0, "R7 full drop");
    slot(1, 1, 2, 231, 1, "R7 full drop with departure");
    slot(1, 1, 2, 232, 0, "R7 accept after free");
    drain("R7 drain");

    // R8: invalid class tags
    for (int t = NCLS; t < 8; t++) slot(1, t, 1, t, 0, "R8 bad class");
    slot(0, 0, 0, 0, 1, "R8 nothing stored");

    // mixed sweep with pseudo-random stimulus
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        slot(lf[0], int'(lf[3:1]) % 6, int'(lf[5:4]), int'(lf[13:6]), lf[14] | lf[15],
             "R2 R4 R10 mix");
      end
    end
    drain("mix drain");

    // R9: saturation
    for (int i = 0; i < 300; i++) slot(1, 7, 0, 0, 0, "R9 sat");
    chk(drop_cnt == 8'hff, "R9 saturated", int'(drop_cnt), 255);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule